// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Register Block

This block keeps the result of a DMA transfer where software can find it and turns that result into a level interrupt for the processor. The transfer engine reports what happens as single-cycle event pulses: done, pause, abort and four kinds of bus error. The block catches each pulse in a sticky status bit. Busy is different: it is passed through live from the engine. Software reads an eight-bit status word at any time after it starts a transfer, so it can poll for the result instead of waiting for the interrupt.

Any event also sets one pending-interrupt flag. That flag reaches the interrupt output only when software has turned the interrupt on in an enable register and also cleared it in a separate mask register. Software removes the pending flag, and also any chosen sticky status bits, by writing ones to a write-one-to-clear register. An engine start pulse wipes all sticky status bits so the next transfer begins from a clean status word.

Access is through a small register bus with a write strobe, a two-bit address and eight-bit data. Read data is combinational from the address.

Top module: `dma_stat_irq`

## Requirements
- R1: Pulses on `eng_evt` set status bits: `eng_evt[k]` sets status bit k+1. The status bits, from bit 7 down to bit 1, are master abort signalled, target abort received, retry limit reached, processor bus timeout, abort, pause and done. Each set bit stays set until a start or a clear removes it.
- R2: Status bit 0 is busy. It always equals the current `eng_busy` input and holds no state.
- R3: A one written to bit k (k from 1 to 7) of the clear register at address 3 clears status bit k. An `eng_start` pulse clears status bits 7 to 1. An event that arrives in the same cycle as a clear or a start wins, and its bit ends up set.
- R4: Any event pulse sets the pending interrupt. Writing a one to bit 0 of the clear register removes it. An event in the same cycle as that clear wins.
- R5: `irq_o` is high only when the interrupt is pending, the enable bit (address 1, bit 0) is 1 and the mask bit (address 2, bit 0) is 0.
- R6: Zero bits written to the clear register have no effect. The clear register always reads as zero.
- R7: After reset, the status reads 0 apart from live busy, the enable reads 0, the mask reads 1, nothing is pending and `irq_o` is low.
- R8: Address 0 returns the status word at any time. Writes to address 0 are ignored.
- R9: `eng_start` does not change the pending interrupt, the enable or the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 enable, 2 mask, 3 clear |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| eng_start | input | 1 | Engine start pulse; clears the sticky status |
| eng_busy | input | 1 | Live engine busy level |
| eng_evt | input | 7 | Engine event pulses; bit k maps to status bit k+1 |
| irq_o | output | 1 | Level interrupt to the processor |

## Verification
Directed sequences walk the interrupt gate through every combination of enable and mask. They also force the collisions that decide who wins: an event against a pending clear, an event against a clear of its own status bit, and an event against a start. These separate a correct priority from a reversed one. Zero-valued clear writes and writes to the status address show whether stray writes leave state alone. A long run of random events, starts, busy levels and register writes, checked against a bench model of the requirements, exposes wrong bit mappings and state that leaks between registers.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;

    localparam int STAT_W  = 8;
    localparam int NUM_EVT = STAT_W - 1;
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_ENABLE = 2'd1,
        REG_MASK   = 2'd2,
        REG_CLEAR  = 2'd3
    } reg_sel_e;

    // Status word, bit 7 first
    typedef struct packed {
        logic mabort;
        logic tabort;
        logic retry;
        logic tmo;
        logic abort;
        logic pause;
        logic done;
        logic busy;
    } stat_t;

    // Decoded register write
    typedef struct packed {
        logic               en_wr;
        logic               en_val;
        logic               mask_wr;
        logic               mask_val;
        logic [NUM_EVT-1:0] clr_sticky;
        logic               clr_pend;
    } wr_cmd_t;

    function automatic wr_cmd_t decode_write(logic we, reg_sel_e sel,
                                             logic [STAT_W-1:0] d);
        wr_cmd_t c;
        c = '0;
        if (we) begin
            case (sel)
                REG_ENABLE: begin
                    c.en_wr  = 1'b1;
                    c.en_val = d[0];
                end
                REG_MASK: begin
                    c.mask_wr  = 1'b1;
                    c.mask_val = d[0];
                end
                REG_CLEAR: begin
                    c.clr_sticky = d[STAT_W-1:1];
                    c.clr_pend   = d[0];
                end
                default: ;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/dma_stat_sticky.sv
module dma_stat_sticky
    import dma_stat_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [NUM_EVT-1:0] clr,
    output logic [NUM_EVT-1:0] sts
);

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                sts[g] <= 1'b0;
            else if (evt[g])
                sts[g] <= 1'b1;
            else if (start || clr[g])
                sts[g] <= 1'b0;
        end

        AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
            evt[g] |=> sts[g]); // R3
        AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
            (start || clr[g]) && !evt[g] |=> !sts[g]); // R3
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
            !start && !clr[g] && !evt[g] |=> $stable(sts[g])); // R1
    end

    AST_STS_RESET: assert property (@(posedge clk)
        rst |=> sts == '0); // R7

endmodule

// File: rtl/dma_stat_irqgate.sv
module dma_stat_irqgate
    import dma_stat_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    any_evt,
    input  wr_cmd_t cmd,
    output logic    pend,
    output logic    en,
    output logic    msk,
    output logic    irq_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            en   <= 1'b0;
            msk  <= 1'b1;
        end else begin
            if (any_evt)
                pend <= 1'b1;
            else if (cmd.clr_pend)
                pend <= 1'b0;
            if (cmd.en_wr)
                en <= cmd.en_val;
            if (cmd.mask_wr)
                msk <= cmd.mask_val;
        end
    end

    assign irq_o = pend & en & ~msk;

    AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        any_evt |=> pend); // R4
    AST_PEND_CLR: assert property (@(posedge clk) disable iff (rst)
        cmd.clr_pend && !any_evt |=> !pend); // R4
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> pend); // R5
    AST_GATE_RESET: assert property (@(posedge clk)
        rst |=> !pend && !en && msk && !irq_o); // R7

endmodule

// File: rtl/dma_stat_regif.sv
module dma_stat_regif
    import dma_stat_pkg::*;
(
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    input  stat_t             status,
    input  logic              en,
    input  logic              msk,
    output wr_cmd_t           cmd,
    output logic [STAT_W-1:0] reg_rdata
);

    reg_sel_e sel;

    assign sel = reg_sel_e'(reg_addr);
    assign cmd = decode_write(reg_we, sel, reg_wdata);

    always_comb begin
        case (sel)
            REG_STATUS: reg_rdata = status;
            REG_ENABLE: reg_rdata = {{(STAT_W-1){1'b0}}, en};
            REG_MASK:   reg_rdata = {{(STAT_W-1){1'b0}}, msk};
            default:    reg_rdata = '0;
        endcase
    end

    always_comb begin
        if (sel == REG_CLEAR)
            AST_CLEAR_READS_ZERO: assert (reg_rdata == '0); // R6
    end

endmodule

// File: rtl/dma_stat_irq.sv
module dma_stat_irq
    import dma_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    input  logic              eng_start,
    input  logic              eng_busy,
    input  logic [NUM_EVT-1:0] eng_evt,
    output logic              irq_o
);

    wr_cmd_t            cmd;
    logic [NUM_EVT-1:0] sts;
    logic               pend;
    logic               en;
    logic               msk;
    stat_t              status;

    assign status = stat_t'({sts, eng_busy});

    dma_stat_regif i_regif (
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status    (status),
        .en        (en),
        .msk       (msk),
        .cmd       (cmd),
        .reg_rdata (reg_rdata)
    );

    dma_stat_sticky i_sticky (
        .clk   (clk),
        .rst   (rst),
        .start (eng_start),
        .evt   (eng_evt),
        .clr   (cmd.clr_sticky),
        .sts   (sts)
    );

    dma_stat_irqgate i_gate (
        .clk     (clk),
        .rst     (rst),
        .any_evt (|eng_evt),
        .cmd     (cmd),
        .pend    (pend),
        .en      (en),
        .msk     (msk),
        .irq_o   (irq_o)
    );

    AST_START_KEEPS_PEND: assert property (@(posedge clk) disable iff (rst)
        eng_start && !cmd.clr_pend |=> pend == $past(pend) || pend); // R9

endmodule

// File: tb/test_dma_stat_irq.sv
module test_dma_stat_irq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       eng_start = 1'b0;
    logic       eng_busy = 1'b0;
    logic [6:0] eng_evt = 7'd0;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;

    // Bench model
    logic [6:0] m_sts;
    logic       m_pend, m_en, m_msk;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_stat_irq i_dma_stat_irq (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
        .eng_busy(eng_busy), .eng_evt(eng_evt), .irq_o(irq_o)
    );

    function automatic logic [7:0] exp_read(logic [1:0] a);
        case (a)
            2'd0:    return {m_sts, eng_busy};
            2'd1:    return {7'd0, m_en};
            2'd2:    return {7'd0, m_msk};
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return m_pend & m_en & ~m_msk;
    endfunction

    task automatic chk(logic [7:0] act, logic [7:0] exp, string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock with the given inputs, model update, then check irq_o
    task automatic step(logic st, logic [6:0] ev, logic we,
                        logic [1:0] a, logic [7:0] d, string req);
        logic [7:0] clr;
        @(negedge clk);
        eng_start = st; eng_evt = ev; reg_we = we; reg_addr = a; reg_wdata = d;
        clr = (we && a == 2'd3) ? d : 8'd0;
        @(posedge clk);
        for (int k = 0; k < 7; k++)
            if (ev[k]) m_sts[k] = 1'b1;
            else if (st || clr[k+1]) m_sts[k] = 1'b0;
        if (|ev) m_pend = 1'b1;
        else if (clr[0]) m_pend = 1'b0;
        if (we && a == 2'd1) m_en = d[0];
        if (we && a == 2'd2) m_msk = d[0];
        #(CLK_PERIOD/4);
        eng_start = 1'b0; eng_evt = '0; reg_we = 1'b0;
        chk({7'd0, irq_o}, {7'd0, exp_irq()}, req);
    endtask

    task automatic rd(logic [1:0] a, string req);
        reg_we = 1'b0; reg_addr = a;
        #1;
        chk(reg_rdata, exp_read(a), req);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d, string req);
        step(1'b0, 7'd0, 1'b1, a, d, req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // Reset, R7
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_sts = '0; m_pend = 1'b0; m_en = 1'b0; m_msk = 1'b1;
        chk(reg_rdata, 8'h00, "R7 status");
        rd(2'd1, "R7 enable");
        chk(reg_rdata, 8'h00, "R7 enable value");
        rd(2'd2, "R7 mask");
        chk(reg_rdata, 8'h01, "R7 mask value");
        rd(2'd3, "R6 clear reads zero");
        chk({7'd0, irq_o}, 8'h00, "R7 irq");

        // R2 live busy
        eng_busy = 1'b1; rd(2'd0, "R2 busy high");
        chk(reg_rdata, 8'h01, "R2 busy bit0");
        eng_busy = 1'b0; rd(2'd0, "R2 busy low");

        // R1 done event, R5 gating
        step(1'b0, 7'h01, 1'b0, 2'd0, 8'd0, "R5 disabled");
        rd(2'd0, "R1 done sticky");
        chk(reg_rdata, 8'h02, "R1 done at bit1");
        wr(2'd1, 8'h01, "R5 enabled but masked");
        chk({7'd0, irq_o}, 8'h00, "R5 masked");
        wr(2'd2, 8'h00, "R5 enabled and unmasked");
        chk({7'd0, irq_o}, 8'h01, "R5 irq asserted");
        wr(2'd2, 8'h01, "R5 masked again");
        wr(2'd2, 8'h00, "R5 unmasked again");

        // R8 write to status ignored
        wr(2'd0, 8'hFF, "R8 status write");
        rd(2'd0, "R8 status unchanged");

        // R6 zero clear write
        wr(2'd3, 8'h00, "R6 zero clear");
        rd(2'd0, "R6 status kept");
        chk({7'd0, irq_o}, 8'h01, "R6 irq kept");

        // R4 event wins over pending clear
        step(1'b0, 7'h01, 1'b1, 2'd3, 8'h01, "R4 event beats clear");
        chk({7'd0, irq_o}, 8'h01, "R4 still pending");
        wr(2'd3, 8'h01, "R4 clear pending");
        chk({7'd0, irq_o}, 8'h00, "R4 cleared");
        rd(2'd0, "R4 clear leaves status");

        // R9 start clears sticky but not pending
        step(1'b0, 7'h40, 1'b0, 2'd0, 8'd0, "R1 master abort");
        rd(2'd0, "R1 mabort bit7");
        chk(reg_rdata, 8'h82, "R1 mabort value");
        step(1'b1, 7'h00, 1'b0, 2'd0, 8'd0, "R9 start keeps pending");
        chk({7'd0, irq_o}, 8'h01, "R9 irq after start");
        rd(2'd0, "R3 start clears sticky");
        chk(reg_rdata, 8'h00, "R3 start value");

        // R3 per-bit clear and event collision
        step(1'b0, 7'h7F, 1'b0, 2'd0, 8'd0, "R1 all events");
        rd(2'd0, "R1 all set");
        wr(2'd3, 8'h04, "R3 clear pause");
        rd(2'd0, "R3 pause cleared");
        chk(reg_rdata, 8'hFA, "R3 pause value");
        step(1'b0, 7'h02, 1'b1, 2'd3, 8'h04, "R3 event beats clear");
        rd(2'd0, "R3 pause kept");
        chk(reg_rdata, 8'hFE, "R3 collision value");
        step(1'b1, 7'h08, 1'b0, 2'd0, 8'd0, "R3 event beats start");
        rd(2'd0, "R3 only timeout left");
        chk(reg_rdata, 8'h10, "R3 start collision value");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [6:0] ev;
            logic       st, we;
            logic [1:0] a;
            logic [7:0] d;
            ev = ($urandom % 6 == 0) ? 7'($urandom) : 7'd0;
            st = ($urandom % 10 == 0);
            we = ($urandom % 3 == 0);
            a  = 2'($urandom);
            d  = 8'($urandom);
            eng_busy = 1'($urandom);
            step(st, ev, we, a, d, "R5 random irq");
            if (i % 4 == 0) rd(2'($urandom), "R1 random read");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule